// File: doc/BRIEF.md
# Two-Stage Contrast Register Front End

This block is the host-facing register front end of a display driver controller. A host drives an 8-bit parallel bus with an active-low chip select, a register-select line, and active-low read and write strobes. All bus inputs are assumed to be already synchronous to the block clock. A write takes effect when the write strobe rises while chip select is low. With the register-select line low, the byte writes a bank-select register. With it high, the upper nibble of the byte names a field and the lower nibble carries that field's value.

The 7-bit contrast code is loaded in two halves. The upper three bits go into a holding register and leave the output untouched. The lower four bits then commit the whole code in one step, and this is the only path that updates the level used downstream. A 4-bit offset setting is added to the committed code, and the sum saturates instead of wrapping.

Reads are indirect. The host first selects the extension bank and writes a 4-bit read address. It then writes the bank that holds the target. A read with the register-select line high then returns the register chosen by that bank and address.

Top module: `stg_reg_front`

## Requirements
- R1: After reset the committed code `level_o` and the holding register are midscale (0x40), the offset is 0, `sum_o` is 0x40, the bank register is 0 and the read address is 0xC.
- R2: A write is accepted only in the cycle where `wr_ni` is high after being low on the previous clock while `cs_ni` is low. The new state is visible one clock later. A strobe rise with `cs_ni` high changes nothing.
- R3: In bank 0, a write with `rs_i`=1 and field 0x1 loads `din_i[2:0]` into the holding register and leaves `level_o` unchanged.
- R4: In bank 0, a write with `rs_i`=1 and field 0x2 sets `level_o` to {holding register, `din_i[3:0]`} on the clock after the accepting cycle.
- R5: A field 0x2 write that has no field 0x1 write before it uses the holding value from the last upper write, or the reset value.
- R6: `sum_o` equals `level_o` plus the offset, capped at 127. In bank 0, field 0x3 loads the offset from `din_i[3:0]`.
- R7: A write with `rs_i`=0 loads `din_i[2:0]` into the bank register.
- R8: Field 0xA loads the read address from `din_i[3:0]` only while the bank register is 4. In any other bank that write has no effect.
- R9: Writes to fields 0x1, 0x2 and 0x3 take effect only in bank 0. In other banks they change neither `level_o`, `sum_o` nor any value read back.
- R10: `dout_oe_o` is high exactly while `cs_ni` and `rd_ni` are both low. `dout_o` is 0 whenever `dout_oe_o` is low.
- R11: Read data with `rs_i`=0 is the bank register, zero-extended. With `rs_i`=1 in bank 0 it depends on the read address: 0x1 gives the holding register, 0x2 the offset, 0x3 the sum and 0xC the committed code. Other addresses in bank 0 read 0. In bank 4 the read returns the read address. Every other bank reads 0.

Port order for the table below follows the module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rs_i | input | 1 | Register select: 0 bank register, 1 field access |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, sampled on its rise |
| din_i | input | 8 | Host write data |
| dout_o | output | 8 | Host read data |
| dout_oe_o | output | 1 | Read data drive enable |
| level_o | output | 7 | Committed contrast code |
| sum_o | output | 7 | Committed code plus offset, saturated |

## Verification
A commit of the lower contrast half can fall in the same cycle as a live read of the committed code. The bench provokes this by holding chip select and the read strobe low on address 0xC in bank 0 while it pulses the write strobe with a field 0x2 byte. In the accepting cycle the read must still show the old code, and one clock later it must show the merged code, with no intermediate value in between. Constrained random bus traffic mixes bank changes, ignored writes and reads against a bench model, and this adds more cases where staging, bank gating and readback meet.

// File: rtl/stg_reg_pkg.sv
package stg_reg_pkg;
  localparam logic [3:0] FLD_CODE_HI = 4'h1;
  localparam logic [3:0] FLD_CODE_LO = 4'h2;
  localparam logic [3:0] FLD_OFFSET  = 4'h3;
  localparam logic [3:0] FLD_RADDR   = 4'hA;

  localparam logic [3:0] RSEL_SHADOW = 4'h1;
  localparam logic [3:0] RSEL_OFFSET = 4'h2;
  localparam logic [3:0] RSEL_SUM    = 4'h3;
  localparam logic [3:0] RSEL_LEVEL  = 4'hC;

  localparam logic [2:0] BANK_MAIN = 3'd0;
  localparam logic [2:0] BANK_EXT  = 3'd4;

  typedef struct packed {
    logic bank_we;
    logic hi_we;
    logic lo_we;
    logic ofs_we;
    logic ra_we;
  } wr_dec_t;
endpackage

// File: rtl/stg_strobe_edge.sv
module stg_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic wr_fire_o,
  output logic rd_live_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign wr_fire_o = !wr_q && wr_ni && !cs_ni;
  assign rd_live_o = !cs_ni && !rd_ni;
endmodule

// File: rtl/stg_volume_stage.sv
module stg_volume_stage #(
  parameter int CODE_W = 7,
  parameter int UP_W   = 3,
  parameter int OFS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic              ofs_we_i,
  input  logic [UP_W-1:0]   hi_val_i,
  input  logic [CODE_W-UP_W-1:0] lo_val_i,
  input  logic [OFS_W-1:0]  ofs_val_i,
  output logic [UP_W-1:0]   shadow_o,
  output logic [CODE_W-1:0] level_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic [CODE_W-1:0] sum_o
);
  localparam int LO_W = CODE_W - UP_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  function automatic logic [CODE_W-1:0] merge_code(input logic [UP_W-1:0] hi,
                                                   input logic [LO_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [CODE_W-1:0] sat_add(input logic [CODE_W-1:0] a,
                                                input logic [OFS_W-1:0] b);
    logic [CODE_W:0] wide;
    wide = {1'b0, a} + (CODE_W+1)'(b);
    return wide[CODE_W] ? TOP : wide[CODE_W-1:0];
  endfunction

  logic [UP_W-1:0]   shadow_q;
  logic [CODE_W-1:0] level_q;
  logic [OFS_W-1:0]  ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= MID[CODE_W-1:LO_W];
      level_q  <= MID;
      ofs_q    <= '0;
    end else begin
      if (hi_we_i)  shadow_q <= hi_val_i;
      if (lo_we_i)  level_q  <= merge_code(shadow_q, lo_val_i);
      if (ofs_we_i) ofs_q    <= ofs_val_i;
    end
  end

  assign shadow_o = shadow_q;
  assign level_o  = level_q;
  assign offset_o = ofs_q;
  assign sum_o    = sat_add(level_q, ofs_q);
endmodule

// File: rtl/stg_read_mux.sv
module stg_read_mux
  import stg_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 7,
  parameter int UP_W   = 3,
  parameter int OFS_W  = 4,
  parameter int RA_W   = 4,
  parameter int BANK_W = 3
) (
  input  logic              rd_live_i,
  input  logic              rs_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [RA_W-1:0]   ra_i,
  input  logic [UP_W-1:0]   shadow_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [CODE_W-1:0] sum_i,
  input  logic [CODE_W-1:0] level_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (!rs_i) begin
      sel = DATA_W'(bank_i);
    end else if (bank_i == BANK_W'(BANK_MAIN)) begin
      case (ra_i)
        RA_W'(RSEL_SHADOW): sel = DATA_W'(shadow_i);
        RA_W'(RSEL_OFFSET): sel = DATA_W'(offset_i);
        RA_W'(RSEL_SUM):    sel = DATA_W'(sum_i);
        RA_W'(RSEL_LEVEL):  sel = DATA_W'(level_i);
        default:            sel = '0;
      endcase
    end else if (bank_i == BANK_W'(BANK_EXT)) begin
      sel = DATA_W'(ra_i);
    end
  end

  assign oe_o   = rd_live_i;
  assign dout_o = rd_live_i ? sel : '0;
endmodule

// File: rtl/stg_reg_front.sv
module stg_reg_front
  import stg_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 7,
  parameter int UP_W   = 3,
  parameter int OFS_W  = 4,
  parameter int RA_W   = 4,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rs_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic [CODE_W-1:0] level_o,
  output logic [CODE_W-1:0] sum_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam int LO_W  = CODE_W - UP_W;
  localparam logic [RA_W-1:0] RA_RST = RA_W'(RSEL_LEVEL);

  logic wr_fire, rd_live;
  logic [NIB_W-1:0] fld, nib;
  wr_dec_t dec;
  logic upper_we, lower_we;
  logic [BANK_W-1:0] bank_q;
  logic [RA_W-1:0]   ra_q;
  logic [UP_W-1:0]   shadow;
  logic [OFS_W-1:0]  offset;

  stg_strobe_edge edge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .wr_fire_o(wr_fire), .rd_live_o(rd_live)
  );

  assign fld = din_i[DATA_W-1:NIB_W];
  assign nib = din_i[NIB_W-1:0];

  always_comb begin
    dec = '0;
    if (wr_fire) begin
      if (!rs_i) begin
        dec.bank_we = 1'b1;
      end else if (bank_q == BANK_W'(BANK_MAIN)) begin
        dec.hi_we  = (fld == NIB_W'(FLD_CODE_HI));
        dec.lo_we  = (fld == NIB_W'(FLD_CODE_LO));
        dec.ofs_we = (fld == NIB_W'(FLD_OFFSET));
      end else if (bank_q == BANK_W'(BANK_EXT)) begin
        dec.ra_we  = (fld == NIB_W'(FLD_RADDR));
      end
    end
  end

  assign upper_we = dec.hi_we;
  assign lower_we = dec.lo_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      ra_q   <= RA_RST;
    end else begin
      if (dec.bank_we) bank_q <= din_i[BANK_W-1:0];
      if (dec.ra_we)   ra_q   <= nib[RA_W-1:0];
    end
  end

  stg_volume_stage #(.CODE_W(CODE_W), .UP_W(UP_W), .OFS_W(OFS_W)) vol_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hi_we_i(upper_we), .lo_we_i(lower_we), .ofs_we_i(dec.ofs_we),
    .hi_val_i(nib[UP_W-1:0]), .lo_val_i(nib[LO_W-1:0]), .ofs_val_i(nib[OFS_W-1:0]),
    .shadow_o(shadow), .level_o(level_o), .offset_o(offset), .sum_o(sum_o)
  );

  stg_read_mux #(.DATA_W(DATA_W), .CODE_W(CODE_W), .UP_W(UP_W), .OFS_W(OFS_W),
                 .RA_W(RA_W), .BANK_W(BANK_W)) rmux_i (
    .rd_live_i(rd_live), .rs_i(rs_i), .bank_i(bank_q), .ra_i(ra_q),
    .shadow_i(shadow), .offset_i(offset), .sum_i(sum_o), .level_i(level_o),
    .dout_o(dout_o), .oe_o(dout_oe_o)
  );
endmodule

// File: rtl/stg_reg_front_chk.sv
module stg_reg_front_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 7,
  parameter int RA_W   = 4,
  parameter int BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_oe_o,
  input logic [CODE_W-1:0] level_o,
  input logic [CODE_W-1:0] sum_o,
  input logic              upper_we,
  input logic              lower_we,
  input logic [RA_W-1:0]   ra_q,
  input logic [BANK_W-1:0] bank_q
);
  a_r3_upper_no_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upper_we |=> $stable(level_o));

  a_r4_lower_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lower_we |=> level_o[3:0] == $past(din_i[3:0]));

  a_r2_no_cs_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(level_o) && $stable(ra_q) && $stable(bank_q)));

  a_r6_sum_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o >= level_o);

  a_r8_ra_bank_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ra_q) |-> $past(bank_q) == BANK_W'(4));

  a_r10_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (!dout_oe_o && dout_o == '0));
endmodule

bind stg_reg_front stg_reg_front_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W),
                                       .RA_W(RA_W), .BANK_W(BANK_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .din_i(din_i),
  .dout_o(dout_o), .dout_oe_o(dout_oe_o), .level_o(level_o), .sum_o(sum_o),
  .upper_we(upper_we), .lower_we(lower_we), .ra_q(ra_q), .bank_q(bank_q)
);

// File: tb/stg_reg_front_tb.sv
module stg_reg_front_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic oe;
  logic [6:0] level, sum;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [2:0] m_shadow = 3'b100;
  logic [6:0] m_level = 7'h40;
  logic [3:0] m_ofs = 4'h0;
  logic [2:0] m_bank = 3'd0;
  logic [3:0] m_ra = 4'hC;

  always #(CLK_P/2) clk = ~clk;

  stg_reg_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rs_i(rs), .rd_ni(rd_n), .wr_ni(wr_n),
    .din_i(din), .dout_o(dout), .dout_oe_o(oe), .level_o(level), .sum_o(sum)
  );

  function automatic logic [6:0] f_sum(input logic [6:0] a, input logic [3:0] b);
    int s;
    s = int'(a) + int'(b);
    return (s > 127) ? 7'd127 : s[6:0];
  endfunction

  function automatic logic [7:0] f_read(input logic r);
    if (!r) return {5'd0, m_bank};
    if (m_bank == 3'd4) return {4'd0, m_ra};
    if (m_bank != 3'd0) return 8'd0;
    case (m_ra)
      4'h1: return {5'd0, m_shadow};
      4'h2: return {4'd0, m_ofs};
      4'h3: return {1'b0, f_sum(m_level, m_ofs)};
      4'hC: return {1'b0, m_level};
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic r, input logic [7:0] d);
    if (!r) m_bank = d[2:0];
    else if (m_bank == 3'd0) begin
      case (d[7:4])
        4'h1: m_shadow = d[2:0];
        4'h2: m_level = {m_shadow, d[3:0]};
        4'h3: m_ofs = d[3:0];
        default: ;
      endcase
    end else if (m_bank == 3'd4 && d[7:4] == 4'hA) m_ra = d[3:0];
  endtask

  task automatic bus_write(input logic csv, input logic r, input logic [7:0] d);
    @(negedge clk); cs_n = csv; rs = r; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    if (!csv) model_write(r, d);
  endtask

  task automatic check_outs(input string req);
    check(level == m_level, {req, " level"}, level, m_level);
    check(sum == f_sum(m_level, m_ofs), {req, " sum"}, sum, f_sum(m_level, m_ofs));
  endtask

  task automatic bus_read(input logic r, input string req);
    @(negedge clk); cs_n = 1'b0; rs = r; rd_n = 1'b0;
    #1;
    check(oe == 1'b1, {req, " oe"}, oe, 1);
    check(dout == f_read(r), {req, " data"}, dout, f_read(r));
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    #1;
    check(oe == 1'b0 && dout == 8'd0, "R10 idle bus", dout, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(level == 7'h40, "R1 level", level, 7'h40);
    check(sum == 7'h40, "R1 sum", sum, 7'h40);
    check(oe == 1'b0 && dout == 8'd0, "R10 reset idle", dout, 0);
    bus_read(1'b1, "R1 ra reset reads level");
    bus_read(1'b0, "R1 bank reset");

    // R3 upper write leaves level
    bus_write(1'b0, 1'b1, 8'h17);
    check_outs("R3 upper only");
    bus_read(1'b1, "R3 level still old");
    // R4 lower commits
    bus_write(1'b0, 1'b1, 8'h25);
    check(level == 7'h75, "R4 commit", level, 7'h75);
    // R5 lower without fresh upper
    bus_write(1'b0, 1'b1, 8'h2A);
    check(level == 7'h7A, "R5 held shadow", level, 7'h7A);
    // R2 cs high ignored
    bus_write(1'b1, 1'b1, 8'h20);
    check_outs("R2 cs high ignored");
    // R6 saturation
    bus_write(1'b0, 1'b1, 8'h2F);
    bus_write(1'b0, 1'b1, 8'h3F);
    check(sum == 7'd127, "R6 saturate", sum, 127);
    bus_write(1'b0, 1'b1, 8'h30);
    check_outs("R6 zero offset");
    // R8 ra write in bank 0 ignored
    bus_write(1'b0, 1'b1, 8'hA1);
    bus_read(1'b1, "R8 ra ignored in bank0");
    // R7 bank write, R8 ra write in ext bank, R9 field writes ignored there
    bus_write(1'b0, 1'b0, 8'h04);
    bus_read(1'b0, "R7 bank readback");
    bus_write(1'b0, 1'b1, 8'hA3);
    bus_read(1'b1, "R11 ext bank returns ra");
    bus_write(1'b0, 1'b1, 8'h20);
    bus_write(1'b0, 1'b1, 8'h35);
    check_outs("R9 ext bank no commit");
    bus_write(1'b0, 1'b0, 8'h00);
    bus_read(1'b1, "R11 sum via ra 3");

    // Read held across a lower commit in the same cycle
    bus_write(1'b0, 1'b0, 8'h04);
    bus_write(1'b0, 1'b1, 8'hAC);
    bus_write(1'b0, 1'b0, 8'h00);
    bus_write(1'b0, 1'b1, 8'h12);
    @(negedge clk); cs_n = 1'b0; rs = 1'b1; rd_n = 1'b0; din = 8'h29; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    #1 check(dout == {1'b0, m_level}, "R4 read old in accept cycle", dout, m_level);
    model_write(1'b1, 8'h29);
    @(negedge clk);
    #1 check(dout == 8'h29, "R4 read new after commit", dout, 8'h29);
    rd_n = 1'b1; cs_n = 1'b1;

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 10);
      d = 8'($urandom);
      case ($urandom % 6)
        0: d[7:4] = 4'h1;
        1: d[7:4] = 4'h2;
        2: d[7:4] = 4'h3;
        3: d[7:4] = 4'hA;
        default: ;
      endcase
      if (op < 2) begin
        d = ($urandom % 2 == 0) ? 8'h00 : (($urandom % 2 == 0) ? 8'h04 : 8'($urandom % 8));
        bus_write(($urandom % 8) == 0, 1'b0, d);
        check_outs("R7 random bank write");
      end else if (op < 7) begin
        bus_write(($urandom % 8) == 0, 1'b1, d);
        check_outs("R9 random field write");
      end else begin
        bus_read(op[0], "R11 random read");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule